// File: doc/BRIEF.md
# Keyboard Auto-Repeat Controller

This block sits after a keyboard scanner and decides when a key event leaves it. On every scan pass the scanner raises `scan_tick` for one clock and presents either a scan code with `key_valid` set or no key at all. A code that differs from the one seen on the previous pass produces one key event at once. A code that stays the same pass after pass is a held key. Once a fixed initial wait has run out, a held key may produce repeat events at a fixed, shorter interval.

A mode register sets which held keys may repeat. It can allow every key, allow no key, or allow only the editing subset: cursor, space and insert/delete keys. An upstream classifier marks those keys through `key_is_edit`. The two countdown reload values are build constants and no register can change them.

Top module: `kbr_top`

## Requirements
- R1: After reset, `mode_rd` reads 0x80 and `evt_valid` is low.
- R2: A pass with `key_valid` high raises `evt_valid` for one clock in the cycle after the tick, with `evt_code` equal to the pass's code, when the previous pass had no key or a different code.
- R3: A held key produces no event on its 1st to 19th held pass after the press.
- R4: When a held key may repeat, it produces a repeat event carrying its code on the 20th held pass after the press (16 delay passes, then 4 repeat passes) and on every 4th held pass after that.
- R5: When `mode_rd` bit 7 is 1, every held key may repeat, whatever bit 6 and `key_is_edit` are.
- R6: When bit 7 is 0 and bit 6 is 1, no held key repeats, and only the first press event appears.
- R7: When bits 7 and 6 are both 0, a held key repeats only if `key_is_edit` is 1.
- R8: A pass with `key_valid` low emits nothing and restarts both countdowns, so a later press of the same code is a new press with the full delay.
- R9: A change to a different code without an intervening no-key pass emits that code at once and restarts the full delay.
- R10: `evt_valid` is low in every cycle that does not follow a tick. Key inputs outside a tick are ignored and do not shift the repeat schedule.
- R11: A clock with `mode_wr` high loads `mode_wdata` into the mode register, which reads back on `mode_rd` from the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| scan_tick | input | 1 | One-clock strobe marking a scan pass |
| key_valid | input | 1 | A key is present on this pass |
| scan_code | input | CODE_W | Scan code of the present key |
| key_is_edit | input | 1 | Code is a cursor, space or insert/delete key |
| mode_wr | input | 1 | Mode register write strobe |
| mode_wdata | input | 8 | Mode value to write (bit 7 all repeat, bit 6 none repeat) |
| mode_rd | output | 8 | Current mode register value |
| evt_valid | output | 1 | One-clock key event strobe |
| evt_code | output | CODE_W | Scan code carried by the event |

## Verification
The assertions check on every cycle that events follow only ticks and key-bearing passes, that every new press produces an event carrying its code, and that a repeat carries the held code. They also check that nothing appears in the initial wait window or while repeating is barred by the mode. The timing of the repeat cadence at passes 20, 24 and 28 is shown only by the bench's scenarios. So is the edit-key filter in the subset mode, and so are restarts after release or a code change. The same holds for the claim that stray inputs between ticks leave the schedule untouched.

// File: rtl/kbr_pkg.sv
package kbr_pkg;
    typedef logic [7:0] kbr_mode_t;
    localparam int MODE_ALL_BIT  = 7;
    localparam int MODE_NONE_BIT = 6;
    localparam kbr_mode_t MODE_RESET_VAL = 8'h80;
endpackage

// File: rtl/kbr_mode_reg.sv
module kbr_mode_reg
    import kbr_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      wr,
    input  kbr_mode_t wdata,
    output kbr_mode_t mode_q
);
    kbr_mode_t mode_d;

    always_comb begin
        mode_d = mode_q;
        if (wr) begin
            mode_d = wdata;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q <= MODE_RESET_VAL;
        end else begin
            mode_q <= mode_d;
        end
    end
endmodule

// File: rtl/kbr_policy.sv
module kbr_policy (
    input  logic mode_all,
    input  logic mode_none,
    input  logic is_edit,
    output logic may_repeat
);
    always_comb begin
        if (mode_all) begin
            may_repeat = 1'b1;
        end else if (mode_none) begin
            may_repeat = 1'b0;
        end else begin
            may_repeat = is_edit;
        end
    end
endmodule

// File: rtl/kbr_match.sv
module kbr_match #(
    parameter int CODE_W = 7
) (
    input  logic              prev_valid,
    input  logic [CODE_W-1:0] prev_code,
    input  logic              key_valid,
    input  logic [CODE_W-1:0] code,
    output logic              same_key
);
    always_comb begin
        same_key = prev_valid && key_valid && (prev_code == code);
    end
endmodule

// File: rtl/kbr_top.sv
module kbr_top
    import kbr_pkg::*;
#(
    parameter int CODE_W        = 7,
    parameter int DELAY_RELOAD  = 16,
    parameter int REPEAT_RELOAD = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scan_tick,
    input  logic              key_valid,
    input  logic [CODE_W-1:0] scan_code,
    input  logic              key_is_edit,
    input  logic              mode_wr,
    input  logic [7:0]        mode_wdata,
    output logic [7:0]        mode_rd,
    output logic              evt_valid,
    output logic [CODE_W-1:0] evt_code
);
    localparam int DLY_W = $clog2(DELAY_RELOAD + 1);
    localparam int RPT_W = $clog2(REPEAT_RELOAD + 1);
    localparam logic [DLY_W-1:0] DLY_INIT = DLY_W'(DELAY_RELOAD);
    localparam logic [RPT_W-1:0] RPT_INIT = RPT_W'(REPEAT_RELOAD);

    typedef struct packed {
        logic              prev_valid;
        logic [CODE_W-1:0] prev_code;
        logic [DLY_W-1:0]  dly_cnt;
        logic [RPT_W-1:0]  rpt_cnt;
        logic              evt_valid;
        logic [CODE_W-1:0] evt_code;
    } kbr_state_t;

    kbr_state_t st_d, st_q;
    kbr_mode_t  mode_q;
    logic       may_repeat;
    logic       same_key;

    kbr_mode_reg u_mode (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr     (mode_wr),
        .wdata  (mode_wdata),
        .mode_q (mode_q)
    );

    kbr_policy u_policy (
        .mode_all   (mode_q[MODE_ALL_BIT]),
        .mode_none  (mode_q[MODE_NONE_BIT]),
        .is_edit    (key_is_edit),
        .may_repeat (may_repeat)
    );

    kbr_match #(.CODE_W(CODE_W)) u_match (
        .prev_valid (st_q.prev_valid),
        .prev_code  (st_q.prev_code),
        .key_valid  (key_valid),
        .code       (scan_code),
        .same_key   (same_key)
    );

    always_comb begin
        st_d           = st_q;
        st_d.evt_valid = 1'b0;
        if (scan_tick) begin
            if (!key_valid) begin
                st_d.prev_valid = 1'b0;
                st_d.dly_cnt    = DLY_INIT;
                st_d.rpt_cnt    = RPT_INIT;
            end else if (!same_key) begin
                st_d.prev_valid = 1'b1;
                st_d.prev_code  = scan_code;
                st_d.dly_cnt    = DLY_INIT;
                st_d.rpt_cnt    = RPT_INIT;
                st_d.evt_valid  = 1'b1;
                st_d.evt_code   = scan_code;
            end else if (st_q.dly_cnt != '0) begin
                st_d.dly_cnt = st_q.dly_cnt - 1'b1;
            end else if (may_repeat) begin
                if (st_q.rpt_cnt == RPT_W'(1)) begin
                    st_d.rpt_cnt   = RPT_INIT;
                    st_d.evt_valid = 1'b1;
                    st_d.evt_code  = st_q.prev_code;
                end else begin
                    st_d.rpt_cnt = st_q.rpt_cnt - 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.prev_valid <= 1'b0;
            st_q.prev_code  <= '0;
            st_q.dly_cnt    <= DLY_INIT;
            st_q.rpt_cnt    <= RPT_INIT;
            st_q.evt_valid  <= 1'b0;
            st_q.evt_code   <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign mode_rd   = mode_q;
    assign evt_valid = st_q.evt_valid;
    assign evt_code  = st_q.evt_code;
endmodule

// File: rtl/kbr_checker.sv
module kbr_checker #(
    parameter int CODE_W        = 7,
    parameter int DELAY_RELOAD  = 16,
    parameter int REPEAT_RELOAD = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              scan_tick,
    input logic              key_valid,
    input logic [CODE_W-1:0] scan_code,
    input logic              mode_all,
    input logic              mode_none,
    input logic              evt_valid,
    input logic [CODE_W-1:0] evt_code
);
    logic              ck_pv;
    logic [CODE_W-1:0] ck_pc;
    logic [15:0]       ck_n;
    logic              held;

    assign held = scan_tick && key_valid && ck_pv && (scan_code == ck_pc);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ck_pv <= 1'b0;
            ck_pc <= '0;
            ck_n  <= '0;
        end else if (scan_tick) begin
            if (!key_valid) begin
                ck_pv <= 1'b0;
                ck_n  <= '0;
            end else if (!held) begin
                ck_pv <= 1'b1;
                ck_pc <= scan_code;
                ck_n  <= '0;
            end else if (ck_n != 16'hFFFF) begin
                ck_n <= ck_n + 16'd1;
            end
        end
    end

    a_r10_tick_only: assert property (@(posedge clk) disable iff (!rst_n)
        !scan_tick |=> !evt_valid);

    a_r2_new_press: assert property (@(posedge clk) disable iff (!rst_n)
        (scan_tick && key_valid && !held) |=> (evt_valid && evt_code == $past(scan_code)));

    a_r8_release_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (scan_tick && !key_valid) |=> !evt_valid);

    a_r3_initial_delay: assert property (@(posedge clk) disable iff (!rst_n)
        (held && (int'(ck_n) + 1 < DELAY_RELOAD + REPEAT_RELOAD)) |=> !evt_valid);

    a_r6_none_repeat: assert property (@(posedge clk) disable iff (!rst_n)
        (held && !mode_all && mode_none) |=> !evt_valid);

    a_r4_repeat_code: assert property (@(posedge clk) disable iff (!rst_n)
        (held) |=> (!evt_valid || evt_code == $past(scan_code)));
endmodule

bind kbr_top kbr_checker #(
    .CODE_W        (CODE_W),
    .DELAY_RELOAD  (DELAY_RELOAD),
    .REPEAT_RELOAD (REPEAT_RELOAD)
) u_kbr_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .scan_tick (scan_tick),
    .key_valid (key_valid),
    .scan_code (scan_code),
    .mode_all  (mode_rd[7]),
    .mode_none (mode_rd[6]),
    .evt_valid (evt_valid),
    .evt_code  (evt_code)
);

// File: tb/kbr_top_bench.sv
module kbr_top_bench;
    localparam int CW = 7;
    localparam int D  = 16;
    localparam int R  = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          scan_tick = 1'b0;
    logic          key_valid = 1'b0;
    logic [CW-1:0] scan_code = '0;
    logic          key_is_edit = 1'b0;
    logic          mode_wr = 1'b0;
    logic [7:0]    mode_wdata = '0;
    logic [7:0]    mode_rd;
    logic          evt_valid;
    logic [CW-1:0] evt_code;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;

    // reference model state
    bit            r_pv = 0;
    logic [CW-1:0] r_pc = '0;
    int            r_n = 0;
    logic [7:0]    r_mode = 8'h80;

    always #4 clk = ~clk;

    kbr_top u_kbr_top (
        .clk(clk), .rst_n(rst_n), .scan_tick(scan_tick), .key_valid(key_valid),
        .scan_code(scan_code), .key_is_edit(key_is_edit), .mode_wr(mode_wr),
        .mode_wdata(mode_wdata), .mode_rd(mode_rd), .evt_valid(evt_valid),
        .evt_code(evt_code)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    // one scan pass: tick cycle, then one idle cycle with scrambled inputs
    task automatic pass(input bit kv, input logic [CW-1:0] code, input bit edit, input string tag);
        bit            exp_v;
        logic [CW-1:0] exp_c;
        bit            allowed;
        exp_v = 0;
        exp_c = '0;
        if (!kv) begin
            r_pv = 0;
            r_n  = 0;
        end else if (!r_pv || code != r_pc) begin
            exp_v = 1;
            exp_c = code;
            r_pv  = 1;
            r_pc  = code;
            r_n   = 0;
        end else begin
            r_n++;
            allowed = r_mode[7] || (!r_mode[6] && edit);
            exp_v = allowed && (r_n >= D + R) && (((r_n - D) % R) == 0);
            exp_c = r_pc;
        end
        scan_tick   = 1'b1;
        key_valid   = kv;
        scan_code   = code;
        key_is_edit = edit;
        @(negedge clk);
        check(tag, {31'd0, evt_valid}, {31'd0, exp_v});
        if (exp_v) check(tag, {25'd0, evt_code}, {25'd0, exp_c});
        scan_tick   = 1'b0;
        key_valid   = ~kv;
        scan_code   = code ^ 7'h55;
        key_is_edit = ~edit;
        @(negedge clk);
        check("R10", {31'd0, evt_valid}, 32'd0);
    endtask

    task automatic hold(input logic [CW-1:0] code, input bit edit, input int n, input string tag);
        for (int i = 0; i < n; i++) pass(1'b1, code, edit, tag);
    endtask

    task automatic set_mode(input logic [7:0] m);
        mode_wr    = 1'b1;
        mode_wdata = m;
        @(negedge clk);
        mode_wr    = 1'b0;
        r_mode     = m;
        check("R11", {24'd0, mode_rd}, {24'd0, m});
        check("R10", {31'd0, evt_valid}, 32'd0);
        @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1", {24'd0, mode_rd}, 32'h80);
        check("R1", {31'd0, evt_valid}, 32'd0);

        // R2 R3 R4 R5: all-keys mode, non-edit key held for 30 passes
        hold(7'h05, 1'b0, 31, "R4");
        // R8: release and press same code again
        pass(1'b0, 7'h05, 1'b0, "R8");
        hold(7'h05, 1'b0, 22, "R8");
        // R9: switch code without release
        hold(7'h11, 1'b0, 21, "R9");
        pass(1'b0, '0, 1'b0, "R8");

        // R6: no-repeat mode
        set_mode(8'h40);
        hold(7'h22, 1'b0, 30, "R6");
        pass(1'b0, '0, 1'b0, "R8");
        hold(7'h23, 1'b1, 30, "R6");
        pass(1'b0, '0, 1'b0, "R8");

        // R7: subset mode
        set_mode(8'h00);
        hold(7'h30, 1'b0, 30, "R7");
        pass(1'b0, '0, 1'b0, "R8");
        hold(7'h31, 1'b1, 30, "R7");
        pass(1'b0, '0, 1'b0, "R8");

        // R5: bit 7 wins over bit 6
        set_mode(8'hC0);
        hold(7'h44, 1'b0, 26, "R5");
        pass(1'b0, '0, 1'b0, "R8");

        // R10: extra idle cycles with stray inputs between passes
        set_mode(8'h80);
        for (int i = 0; i < 25; i++) begin
            pass(1'b1, 7'h5A, 1'b0, "R10");
            key_valid = 1'b1;
            scan_code = 7'h01;
            @(negedge clk);
            check("R10", {31'd0, evt_valid}, 32'd0);
        end

        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end
endmodule